// File: doc/BRIEF.md
# Rotate-Through-Carry Unit

This unit rotates an integer operand left or right with the carry flag as one extra bit of the ring. An N-bit operand plus carry forms an (N+1)-bit loop, and the unit supports N = 8, 16, 32 and 64. It takes the operand, a size code, a direction, a shift count and the incoming carry and overflow flags. It returns the rotated operand, the new carry, the new overflow, a flag-write enable and an indicator that the overflow value carries no meaning.

The unit is one pipeline stage inside an execution cluster. Every cycle it samples its inputs, and the results appear on registered outputs one clock later. The count port carries the low six bits of the count, whether that count came from a register or an immediate. The unit trims the count to the range that the operand size allows. It then reduces the trimmed count modulo the ring length before rotating. The flag rules depend on the trimmed count, not on the amount actually rotated.

Top module: `rot_carry_unit`

## Requirements
- R1: The rotation acts on the (N+1)-bit ring formed by carry above the low N operand bits. N is 8, 16, 32 or 64 for size codes 2'b00, 2'b01, 2'b10 and 2'b11.
- R2: The trimmed count is cnt_i[4:0] for sizes 8, 16 and 32, and cnt_i[5:0] for size 64. A count of 32 therefore rotates nothing and writes no flag on a 32-bit operand, but it rotates a 64-bit operand.
- R3: When the trimmed count is 0, flag_we_o is 0, cf_o equals cf_i, of_o equals of_i and res_o equals the operand's low N bits.
- R4: With dir_i = 0 (left), each step moves operand bit N-1 into carry and moves the old carry into bit 0.
- R5: With dir_i = 1 (right), each step moves operand bit 0 into carry and moves the old carry into bit N-1.
- R6: For a right rotate with trimmed count 1, of_o is the old carry XOR operand bit N-1 before the rotate.
- R7: For a left rotate with trimmed count 1, of_o is the new carry XOR result bit N-1.
- R8: When the trimmed count exceeds 1, of_o is 0 and of_undef_o is 1. Otherwise of_undef_o is 0.
- R9: The amount actually rotated is the trimmed count modulo N+1. For example, a count of 9 on an 8-bit operand or 17 on a 16-bit operand leaves the operand and carry unchanged, but flag_we_o is still 1.
- R10: Bits of res_o at and above N are 0.
- R11: While rst is high, every output is 0. Outputs reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| size_i | input | 2 | Operand size code (00=8, 01=16, 10=32, 11=64) |
| dir_i | input | 1 | Direction, 0 left, 1 right |
| cnt_i | input | 6 | Low six bits of the rotate count |
| operand_i | input | 64 | Operand, low N bits used |
| cf_i | input | 1 | Incoming carry flag |
| of_i | input | 1 | Incoming overflow flag |
| res_o | output | 64 | Rotated operand, zero above bit N-1 |
| cf_o | output | 1 | New carry flag |
| of_o | output | 1 | New overflow flag |
| flag_we_o | output | 1 | Flags are to be written |
| of_undef_o | output | 1 | Overflow value is not meaningful |

## Verification
The bench sweeps every size, direction and count from 0 to 63 against a step-by-step reference that rotates one bit at a time. A design that rotated only N bits, or that applied the modulo step wrongly, would fail at counts of N and N+1. The trimming cases come next. At count 32, a 32-bit operand must stay unchanged with no flag write, while a 64-bit operand must rotate. A design that trimmed the count to the same width for every size would either write flags for the 32-bit case or leave the 64-bit operand where it was. Counts of 0, 1 and 2 exercise the flag rules: a wrong design would leak a flag write at zero, take the one-bit overflow from the wrong bit, or leave a stale overflow when its value is undefined.

// File: rtl/rcu_pkg.sv
package rcu_pkg;

    localparam int BASE_W    = 8;
    localparam int NUM_SIZES = 4;
    localparam int DATA_W    = BASE_W << (NUM_SIZES - 1);
    localparam int CNT_W     = 6;
    localparam int SIZE_W    = $clog2(NUM_SIZES);

    typedef enum logic [SIZE_W-1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } size_e;

    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } dir_e;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              cf;
        logic              of;
        logic              we;
        logic              undef;
    } rcu_out_t;

    typedef struct packed {
        logic cf;
        logic of;
        logic we;
        logic undef;
    } rcu_flags_t;

    // Trim the count to the range allowed by the operand size.
    function automatic logic [CNT_W-1:0] mask_count(size_e s, logic [CNT_W-1:0] c);
        logic [CNT_W-1:0] m;
        if (s == SZ_64) m = c;
        else            m = {1'b0, c[CNT_W-2:0]};
        return m;
    endfunction

    // Most significant operand bit for the given size.
    function automatic logic pick_msb(size_e s, logic [DATA_W-1:0] v);
        logic b;
        case (s)
            SZ_8:    b = v[BASE_W-1];
            SZ_16:   b = v[2*BASE_W-1];
            SZ_32:   b = v[4*BASE_W-1];
            default: b = v[DATA_W-1];
        endcase
        return b;
    endfunction

    // Keep only the low N bits for the given size.
    function automatic logic [DATA_W-1:0] size_mask(size_e s, logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        case (s)
            SZ_8:    r = {{(DATA_W-BASE_W){1'b0}},   v[BASE_W-1:0]};
            SZ_16:   r = {{(DATA_W-2*BASE_W){1'b0}}, v[2*BASE_W-1:0]};
            SZ_32:   r = {{(DATA_W-4*BASE_W){1'b0}}, v[4*BASE_W-1:0]};
            default: r = v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rcu_ring_lane.sv
module rcu_ring_lane
    import rcu_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] operand_i,
    input  logic              cf_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              dir_i,
    output logic [LANE_W-1:0] res_o,
    output logic              cf_o
);

    localparam int RING_W = LANE_W + 1;
    localparam int DBL_W  = 2 * RING_W;

    logic [CNT_W-1:0]  amt;
    logic [RING_W-1:0] ring;
    logic [DBL_W-1:0]  dbl;
    logic [DBL_W-1:0]  shl;
    logic [DBL_W-1:0]  shr;
    logic [RING_W-1:0] rot;

    always_comb begin
        amt  = CNT_W'(int'(cnt_i) % RING_W);
        ring = {cf_i, operand_i};
        dbl  = {ring, ring};
        shl  = dbl << amt;
        shr  = dbl >> amt;
        if (dir_e'(dir_i) == DIR_LEFT) rot = shl[DBL_W-1:RING_W];
        else                           rot = shr[RING_W-1:0];
        res_o = rot[LANE_W-1:0];
        cf_o  = rot[RING_W-1];
    end

endmodule

// File: rtl/rcu_flags.sv
module rcu_flags
    import rcu_pkg::*;
(
    input  logic [CNT_W-1:0] mcnt_i,
    input  logic             dir_i,
    input  logic             cf_i,
    input  logic             of_i,
    input  logic             op_msb_i,
    input  logic             res_msb_i,
    input  logic             cf_new_i,
    output rcu_flags_t       flags_o
);

    logic zero_cnt;
    logic one_cnt;

    always_comb begin
        zero_cnt = (mcnt_i == '0);
        one_cnt  = (mcnt_i == CNT_W'(1));
        flags_o.we    = !zero_cnt;
        flags_o.undef = !zero_cnt && !one_cnt;
        flags_o.cf    = zero_cnt ? cf_i : cf_new_i;
        if (zero_cnt)
            flags_o.of = of_i;
        else if (one_cnt)
            flags_o.of = (dir_e'(dir_i) == DIR_RIGHT) ? (cf_i ^ op_msb_i)
                                                      : (cf_new_i ^ res_msb_i);
        else
            flags_o.of = 1'b0;
    end

endmodule

// File: rtl/rot_carry_unit.sv
module rot_carry_unit
    import rcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        size_i,
    input  logic              dir_i,
    input  logic [5:0]        cnt_i,
    input  logic [63:0]       operand_i,
    input  logic              cf_i,
    input  logic              of_i,
    output logic [63:0]       res_o,
    output logic              cf_o,
    output logic              of_o,
    output logic              flag_we_o,
    output logic              of_undef_o
);

    size_e             size;
    logic [CNT_W-1:0]  mcnt;
    logic [DATA_W-1:0] lane_res [NUM_SIZES];
    logic              lane_cf  [NUM_SIZES];
    rcu_flags_t        flags;
    rcu_out_t          nxt;
    rcu_out_t          out_q;
    logic [DATA_W-1:0] sel_res;
    logic              sel_cf;

    assign size = size_e'(size_i);
    assign mcnt = mask_count(size, cnt_i);

    for (genvar gi = 0; gi < NUM_SIZES; gi++) begin : g_lane
        localparam int LW = BASE_W << gi;
        logic [LW-1:0] r;
        logic          c;
        rcu_ring_lane #(.LANE_W(LW)) i_lane (
            .operand_i (operand_i[LW-1:0]),
            .cf_i      (cf_i),
            .cnt_i     (mcnt),
            .dir_i     (dir_i),
            .res_o     (r),
            .cf_o      (c)
        );
        assign lane_res[gi] = DATA_W'(r);
        assign lane_cf[gi]  = c;
    end

    assign sel_res = lane_res[size];
    assign sel_cf  = lane_cf[size];

    rcu_flags i_flags (
        .mcnt_i    (mcnt),
        .dir_i     (dir_i),
        .cf_i      (cf_i),
        .of_i      (of_i),
        .op_msb_i  (pick_msb(size, operand_i)),
        .res_msb_i (pick_msb(size, sel_res)),
        .cf_new_i  (sel_cf),
        .flags_o   (flags)
    );

    always_comb begin
        nxt.res   = sel_res;
        nxt.cf    = flags.cf;
        nxt.of    = flags.of;
        nxt.we    = flags.we;
        nxt.undef = flags.undef;
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= nxt;
    end

    assign res_o      = out_q.res;
    assign cf_o       = out_q.cf;
    assign of_o       = out_q.of;
    assign flag_we_o  = out_q.we;
    assign of_undef_o = out_q.undef;

endmodule

// File: rtl/rcu_checker.sv
module rcu_checker
    import rcu_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [1:0]  size_i,
    input logic        dir_i,
    input logic [5:0]  cnt_i,
    input logic [63:0] operand_i,
    input logic        cf_i,
    input logic        of_i,
    input logic [63:0] res_o,
    input logic        cf_o,
    input logic        of_o,
    input logic        flag_we_o,
    input logic        of_undef_o
);

    logic [CNT_W-1:0]  chk_mcnt;
    logic [DATA_W-1:0] chk_opm;
    logic              chk_msb;

    assign chk_mcnt = mask_count(size_e'(size_i), cnt_i);
    assign chk_opm  = size_mask(size_e'(size_i), operand_i);
    assign chk_msb  = pick_msb(size_e'(size_i), operand_i);

    AST_QUIET_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
        (chk_mcnt == '0) |=> (!flag_we_o && cf_o == $past(cf_i) && of_o == $past(of_i))); // R3

    AST_ZERO_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
        (chk_mcnt == '0) |=> (res_o == $past(chk_opm))); // R3

    AST_RIGHT_ONE_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (chk_mcnt == CNT_W'(1) && dir_i) |=> (of_o == $past(cf_i ^ chk_msb))); // R6

    AST_UNDEF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (chk_mcnt > CNT_W'(1)) |=> (of_undef_o && !of_o && flag_we_o)); // R8

    AST_DEFINED_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (chk_mcnt <= CNT_W'(1)) |=> !of_undef_o); // R8

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (size_i == 2'd0) |=> (res_o[DATA_W-1:BASE_W] == '0)); // R10

    AST_WIDE_COUNT: assert property (@(posedge clk) disable iff (rst)
        (size_i == 2'd3 && cnt_i[5]) |=> flag_we_o); // R2

endmodule

bind rot_carry_unit rcu_checker i_rcu_checker (
    .clk        (clk),
    .rst        (rst),
    .size_i     (size_i),
    .dir_i      (dir_i),
    .cnt_i      (cnt_i),
    .operand_i  (operand_i),
    .cf_i       (cf_i),
    .of_i       (of_i),
    .res_o      (res_o),
    .cf_o       (cf_o),
    .of_o       (of_o),
    .flag_we_o  (flag_we_o),
    .of_undef_o (of_undef_o)
);

// File: tb/test_rot_carry_unit.sv
module test_rot_carry_unit;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [63:0] res;
        logic        cf;
        logic        of;
        logic        we;
        logic        undef;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  size_i = '0;
    logic        dir_i = 1'b0;
    logic [5:0]  cnt_i = '0;
    logic [63:0] operand_i = '0;
    logic        cf_i = 1'b0;
    logic        of_i = 1'b0;
    logic [63:0] res_o;
    logic        cf_o, of_o, flag_we_o, of_undef_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    rot_carry_unit i_rot_carry_unit (
        .clk(clk), .rst(rst), .size_i(size_i), .dir_i(dir_i), .cnt_i(cnt_i),
        .operand_i(operand_i), .cf_i(cf_i), .of_i(of_i), .res_o(res_o),
        .cf_o(cf_o), .of_o(of_o), .flag_we_o(flag_we_o), .of_undef_o(of_undef_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bit-serial reference: one ring step per count, no modulo shortcut.
    function automatic exp_t model(input logic [1:0] sz, input logic dr, input logic [5:0] c,
                                   input logic [63:0] op, input logic cfi, input logic ofi);
        exp_t e;
        int n = 8 << sz;
        int m = (sz == 2'd3) ? int'(c) : int'(c[4:0]);
        logic [63:0] mask = (n == 64) ? '1 : ((64'd1 << n) - 64'd1);
        logic [63:0] v = op & mask;
        logic msb0 = v[n-1];
        logic cf = cfi;
        logic nc;
        logic ofv = ofi;
        for (int k = 0; k < m; k++) begin
            if (!dr) begin
                nc = v[n-1];
                v  = ((v << 1) | {63'd0, cf}) & mask;
            end else begin
                nc = v[0];
                v  = (v >> 1) | ({63'd0, cf} << (n - 1));
            end
            cf = nc;
        end
        if (m == 1)     ofv = dr ? (cfi ^ msb0) : (cf ^ v[n-1]);
        else if (m > 1) ofv = 1'b0;
        e.res = v; e.cf = cf; e.of = ofv; e.we = (m != 0); e.undef = (m > 1);
        return e;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [1:0] sz, input logic dr, input logic [5:0] c,
                       input logic [63:0] op, input logic cfi, input logic ofi, input string extra);
        exp_t e;
        int n = 8 << sz;
        int m = (sz == 2'd3) ? int'(c) : int'(c[4:0]);
        string tdir = dr ? "R1/R5" : "R1/R4";
        string tof  = (m == 0) ? "R3" : (m == 1) ? (dr ? "R6" : "R7") : "R8";
        @(negedge clk);
        size_i = sz; dir_i = dr; cnt_i = c; operand_i = op; cf_i = cfi; of_i = ofi;
        @(negedge clk);
        e = model(sz, dr, c, op, cfi, ofi);
        check(res_o == e.res, $sformatf("%s %s result sz=%0d cnt=%0d", extra, tdir, sz, c), res_o, e.res);
        check(cf_o == e.cf, $sformatf("%s %s carry sz=%0d cnt=%0d", extra, tdir, sz, c), 64'(cf_o), 64'(e.cf));
        check(of_o == e.of, $sformatf("%s %s overflow sz=%0d cnt=%0d", extra, tof, sz, c), 64'(of_o), 64'(e.of));
        check(flag_we_o == e.we, $sformatf("%s R2/R3 write enable sz=%0d cnt=%0d", extra, sz, c), 64'(flag_we_o), 64'(e.we));
        check(of_undef_o == e.undef, $sformatf("%s R8 undefined sz=%0d cnt=%0d", extra, sz, c), 64'(of_undef_o), 64'(e.undef));
        if (n < 64)
            check((res_o >> n) == 64'd0, $sformatf("%s R10 upper bits sz=%0d", extra, sz), res_o >> n, 64'd0);
    endtask

    initial begin
        logic [31:0] seed_v;
        seed_v = $urandom(32'h5eed_0042);
        repeat (3) @(negedge clk);
        // R11: outputs cleared while reset is held
        operand_i = 64'hFFFF_FFFF_FFFF_FFFF; cf_i = 1'b1; of_i = 1'b1; cnt_i = 6'd3;
        @(negedge clk);
        check(res_o == 64'd0 && !cf_o && !of_o && !flag_we_o && !of_undef_o,
              "R11 reset state", {59'd0, res_o != 0, cf_o, of_o, flag_we_o, of_undef_o}, 64'd0);
        rst = 1'b0;

        // Directed corner cases
        run(2'd0, 1'b0, 6'd1, 64'h80, 1'b0, 1'b0, "R1");
        run(2'd0, 1'b1, 6'd1, 64'h01, 1'b1, 1'b0, "R1");
        run(2'd0, 1'b0, 6'd9, 64'hA5, 1'b1, 1'b0, "R9");
        run(2'd1, 1'b1, 6'd17, 64'h1234, 1'b0, 1'b1, "R9");
        run(2'd0, 1'b1, 6'd18, 64'h3C, 1'b1, 1'b1, "R9");
        run(2'd2, 1'b0, 6'd32, 64'hDEAD_BEEF, 1'b1, 1'b1, "R2");
        run(2'd3, 1'b0, 6'd32, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b0, "R2");
        run(2'd0, 1'b0, 6'd40, 64'hFFFF_FFFF_FFFF_FF5A, 1'b0, 1'b1, "R2");
        run(2'd3, 1'b1, 6'd0, 64'hFFFF_0000_FFFF_0000, 1'b1, 1'b1, "R3");
        run(2'd1, 1'b0, 6'd0, 64'hFFFF_FFFF_FFFF_8001, 1'b0, 1'b1, "R3");

        // Full sweep of sizes, directions and counts
        for (int s = 0; s < 4; s++)
            for (int d = 0; d < 2; d++)
                for (int c = 0; c < 64; c++)
                    run(2'(s), 1'(d), 6'(c), {$urandom, $urandom}, 1'($urandom), 1'($urandom), "sweep");

        // Constrained random, counts biased toward the small cases
        for (int i = 0; i < 400; i++) begin
            logic [5:0] c = ($urandom % 4 == 0) ? 6'($urandom % 3) : 6'($urandom);
            run(2'($urandom), 1'($urandom), c, {$urandom, $urandom}, 1'($urandom), 1'($urandom), "rand");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule